// File: doc/BRIEF.md
# NAND Flash Device Bus Front-End

This block is the device side of an 8-bit parallel NAND flash bus, built to run in a system clock domain. The host's strobes (select, command latch, address latch, write, read, write protect) enter through a synchronizer. On each rising write strobe the sampled byte is taken as a command, an address byte or a data byte, depending on the two latch-enable inputs. Commands drive a small sequencer. It covers page read, page program and block erase, plus a status query and a soft reset.

There is no cell array. Program data is loaded into a 528-byte page buffer (512 main bytes and 16 spare bytes), and read operations serve bytes out of that same buffer. A column counter steps on each falling read strobe. Program, erase and read set the ready/busy output low for a number of system clocks given by a parameter. The data bus is split into input, output and output-enable signals.

Top module: `nand_bus_front`

## Requirements
- R1: After reset, rb_n is 1 and dq_oe is 0. A status query at that point returns 0xC0.
- R2: With ce_n low, a rising we_n captures dq_in in one of three ways:
  - as a command when cle=1 and ale=0;
  - as an address byte when ale=1 and cle=0;
  - as a data byte when both are 0.
  An address for read or program is three bytes: the column first (0..255), then two row bytes.
- R3: Command 0x00 followed by three address bytes holds rb_n low for T_READ_CLKS clocks. After that, each falling re_n presents the buffer byte at the column counter on dq_out and increments the counter by one.
- R4: dq_oe is 1 only in these conditions: ce_n is low, re_n is low, and the block is either in status mode or in read-data mode while ready. In every other case it is 0.
- R5: Command 0x80 and three address bytes select a start column. Each following data byte is stored at the column counter, which then increments. Bytes past column 527 are dropped. Command 0x10 then holds rb_n low for T_PROG_CLKS clocks.
- R6: Command 0x60, then two row bytes, then command 0xD0 holds rb_n low for T_ERASE_CLKS clocks.
- R7: If ce_n goes high during a busy period, the busy period still runs its full length.
- R8: While ce_n is high and the block is ready, write and read strobes have no effect: no command is taken and the column counter does not move.
- R9: With wp_n low, the program confirm (0x10) and the erase confirm (0xD0) start no busy period and set the fail flag.
- R10: Command 0x70 enters status mode, and this command is also accepted while busy. The status byte is laid out as follows:
  - bit 7 = wp_n;
  - bit 6 = ready;
  - bit 0 = fail flag;
  - all other bits 0.
  No other command has any effect while busy.
- R11: If spare_sel is low, sequential reads run to column 527. If it is high, they stop after column 511. Reads past the last column return 0xFF and the counter holds.
- R12: Command 0xFF returns the block to idle: it clears the fail flag and leaves output mode, so dq_oe stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| ce_n | input | 1 | Chip select, active low |
| cle | input | 1 | Marks the strobed byte as a command |
| ale | input | 1 | Marks the strobed byte as an address byte |
| we_n | input | 1 | Write strobe; bytes are taken on its rising edge |
| re_n | input | 1 | Read strobe; its falling edge steps the output data |
| wp_n | input | 1 | Write protect, active low |
| spare_sel | input | 1 | Static select: 0 reads through the spare area, 1 stops at the end of main |
| dq_in | input | 8 | Data bus, host to device |
| dq_out | output | 8 | Data bus, device to host |
| dq_oe | output | 1 | Drive enable for dq_out |
| rb_n | output | 1 | Ready (1) / busy (0) |

## Verification
The bench measures the length of every busy period in clocks, starting from the confirming strobe. A timer that is off by one, or that a chip deselect cuts short, shows up as a wrong count.

It runs sequential reads across the main/spare boundary under both settings of the spare select. A counter that wraps, or that ignores the select, returns pattern bytes where 0xFF is expected.

It also checks three cases that a careless design gets wrong:
- Strobes sent while deselected: a design that takes them anyway moves the column counter or switches into status mode.
- Commands sent while busy: only the status query may act, so a soft reset during an erase must not cut the busy period short.
- Confirms sent under write protect: they must not start a busy period and must set the fail bit.

// File: rtl/nfb_pkg.sv
package nfb_pkg;

  typedef enum logic [2:0] {
    M_IDLE,
    M_RD_ADDR,
    M_RD_DATA,
    M_PG_ADDR,
    M_PG_DATA,
    M_ER_ADDR,
    M_ER_WAIT,
    M_STATUS
  } mode_t;

  typedef enum logic [1:0] {
    JOB_READ,
    JOB_PROG,
    JOB_ERASE
  } job_t;

  localparam logic [7:0] OP_READ     = 8'h00;
  localparam logic [7:0] OP_PROG     = 8'h80;
  localparam logic [7:0] OP_PROG_GO  = 8'h10;
  localparam logic [7:0] OP_ERASE    = 8'h60;
  localparam logic [7:0] OP_ERASE_GO = 8'hD0;
  localparam logic [7:0] OP_STATUS   = 8'h70;
  localparam logic [7:0] OP_RESET    = 8'hFF;

  localparam logic [7:0] PAST_END_BYTE = 8'hFF;

endpackage

// File: rtl/nfb_sync.sv
module nfb_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] INIT = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= INIT;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];

endmodule

// File: rtl/nfb_busy_timer.sv
module nfb_busy_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [CNT_W-1:0] dur,
  output logic             busy
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy  <= 1'b0;
      cnt_q <= '0;
    end else if (start && !busy) begin
      busy  <= 1'b1;
      cnt_q <= dur - CNT_W'(1);
    end else if (busy) begin
      if (cnt_q == '0) busy <= 1'b0;
      else             cnt_q <= cnt_q - CNT_W'(1);
    end
  end

  // R10: the sequencer only launches a job while the block is ready
  p_start_idle_r10: assert property (@(posedge clk) disable iff (rst)
    start |-> !busy);

endmodule

// File: rtl/nfb_page_buf.sv
module nfb_page_buf #(
  parameter int DEPTH = 528,
  parameter int AW    = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [7:0]    wr_data,
  input  logic          rd_en,
  input  logic [AW-1:0] rd_addr,
  output logic [7:0]    rd_data
);

  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
    if (rd_en) rd_data <= mem[rd_addr];
  end

  // R5: program bytes past the last column never reach the array
  p_wr_in_range_r5: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> (int'(wr_addr) < DEPTH));

  // R11: reads never address beyond the page
  p_rd_in_range_r11: assert property (@(posedge clk) disable iff (rst)
    rd_en |-> (int'(rd_addr) < DEPTH));

endmodule

// File: rtl/nfb_ctrl.sv
module nfb_ctrl
  import nfb_pkg::*;
#(
  parameter int MAIN_BYTES  = 512,
  parameter int SPARE_BYTES = 16,
  parameter int AW          = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we_rise,
  input  logic          re_fall,
  input  logic          ce_n_s,
  input  logic          cle_s,
  input  logic          ale_s,
  input  logic          re_n_s,
  input  logic          wp_n_s,
  input  logic          spare_off_s,
  input  logic [7:0]    din,
  input  logic          busy,
  output logic          start,
  output job_t          job,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic [7:0]    wr_data,
  output logic          rd_en,
  output logic [AW-1:0] rd_addr,
  output logic          alt_sel,
  output logic [7:0]    alt_byte,
  output logic          oe
);

  localparam int DEPTH = MAIN_BYTES + SPARE_BYTES;
  localparam logic [AW-1:0] LAST_ALL  = AW'(DEPTH - 1);
  localparam logic [AW-1:0] LAST_MAIN = AW'(MAIN_BYTES - 1);
  localparam logic [AW-1:0] END_COL   = AW'(DEPTH);

  mode_t         mode_q;
  logic [1:0]    idx_q;
  logic [AW-1:0] col_q;
  logic          fail_q;

  logic          sel;
  logic          cmd_we, adr_we, dat_we;
  logic [AW-1:0] last_col;
  logic [7:0]    status;

  assign sel      = !ce_n_s;
  assign cmd_we   = we_rise && sel && cle_s && !ale_s;
  assign adr_we   = we_rise && sel && ale_s && !cle_s;
  assign dat_we   = we_rise && sel && !ale_s && !cle_s;
  assign last_col = spare_off_s ? LAST_MAIN : LAST_ALL;
  assign status   = {wp_n_s, !busy, 5'b00000, fail_q};

  always_comb begin
    start = 1'b0;
    job   = JOB_READ;
    if (cmd_we && !busy) begin
      if (din == OP_PROG_GO && mode_q == M_PG_DATA && wp_n_s) begin
        start = 1'b1;
        job   = JOB_PROG;
      end else if (din == OP_ERASE_GO && mode_q == M_ER_WAIT && wp_n_s) begin
        start = 1'b1;
        job   = JOB_ERASE;
      end
    end else if (adr_we && !busy && mode_q == M_RD_ADDR && idx_q == 2'd2) begin
      start = 1'b1;
      job   = JOB_READ;
    end
  end

  assign wr_en   = dat_we && !busy && mode_q == M_PG_DATA && col_q < END_COL;
  assign wr_addr = col_q;
  assign wr_data = din;
  assign rd_en   = re_fall && sel && !busy && mode_q == M_RD_DATA && col_q <= last_col;
  assign rd_addr = col_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q   <= M_IDLE;
      idx_q    <= 2'd0;
      col_q    <= '0;
      fail_q   <= 1'b0;
      alt_sel  <= 1'b0;
      alt_byte <= 8'h00;
      oe       <= 1'b0;
    end else begin
      oe <= sel && !re_n_s &&
            (mode_q == M_STATUS || (mode_q == M_RD_DATA && !busy));

      if (cmd_we) begin
        if (busy) begin
          if (din == OP_STATUS) mode_q <= M_STATUS;
        end else begin
          case (din)
            OP_READ:   begin mode_q <= M_RD_ADDR; idx_q <= 2'd0; end
            OP_PROG:   begin mode_q <= M_PG_ADDR; idx_q <= 2'd0; end
            OP_ERASE:  begin mode_q <= M_ER_ADDR; idx_q <= 2'd0; end
            OP_STATUS: mode_q <= M_STATUS;
            OP_RESET: begin
              mode_q <= M_IDLE;
              idx_q  <= 2'd0;
              col_q  <= '0;
              fail_q <= 1'b0;
            end
            OP_PROG_GO: begin
              if (mode_q == M_PG_DATA) begin
                fail_q <= !wp_n_s;
                mode_q <= M_IDLE;
              end
            end
            OP_ERASE_GO: begin
              if (mode_q == M_ER_WAIT) begin
                fail_q <= !wp_n_s;
                mode_q <= M_IDLE;
              end
            end
            default: ;
          endcase
        end
      end else if (adr_we && !busy) begin
        case (mode_q)
          M_RD_ADDR, M_PG_ADDR: begin
            if (idx_q == 2'd0) col_q <= AW'(din);
            if (idx_q == 2'd2) begin
              idx_q  <= 2'd0;
              mode_q <= (mode_q == M_RD_ADDR) ? M_RD_DATA : M_PG_DATA;
            end else begin
              idx_q <= idx_q + 2'd1;
            end
          end
          M_ER_ADDR: begin
            if (idx_q == 2'd1) begin
              idx_q  <= 2'd0;
              mode_q <= M_ER_WAIT;
            end else begin
              idx_q <= idx_q + 2'd1;
            end
          end
          default: ;
        endcase
      end else if (wr_en) begin
        col_q <= col_q + AW'(1);
      end

      if (re_fall && sel) begin
        if (mode_q == M_STATUS) begin
          alt_sel  <= 1'b1;
          alt_byte <= status;
        end else if (mode_q == M_RD_DATA && !busy) begin
          if (rd_en) begin
            alt_sel <= 1'b0;
            col_q   <= col_q + AW'(1);
          end else begin
            alt_sel  <= 1'b1;
            alt_byte <= PAST_END_BYTE;
          end
        end
      end
    end
  end

  // R4: the bus is only driven after a selected, active read strobe
  p_oe_needs_sel_r4: assert property (@(posedge clk) disable iff (rst)
    oe |-> $past(sel && !re_n_s));

  // R9: the fail flag only rises when write protect was active
  p_fail_only_prot_r9: assert property (@(posedge clk) disable iff (rst)
    $rose(fail_q) |-> $past(!wp_n_s));

  // R11: the column counter stops one past the last column
  p_col_limit_r11: assert property (@(posedge clk) disable iff (rst)
    col_q <= END_COL);

endmodule

// File: rtl/nand_bus_front.sv
module nand_bus_front
  import nfb_pkg::*;
#(
  parameter int MAIN_BYTES   = 512,
  parameter int SPARE_BYTES  = 16,
  parameter int SYNC_STAGES  = 2,
  parameter int T_READ_CLKS  = 12,
  parameter int T_PROG_CLKS  = 40,
  parameter int T_ERASE_CLKS = 120
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       ce_n,
  input  logic       cle,
  input  logic       ale,
  input  logic       we_n,
  input  logic       re_n,
  input  logic       wp_n,
  input  logic       spare_sel,
  input  logic [7:0] dq_in,
  output logic [7:0] dq_out,
  output logic       dq_oe,
  output logic       rb_n
);

  localparam int DEPTH  = MAIN_BYTES + SPARE_BYTES;
  localparam int AW     = $clog2(DEPTH + 1);
  localparam int T_MAX0 = (T_READ_CLKS > T_PROG_CLKS) ? T_READ_CLKS : T_PROG_CLKS;
  localparam int T_MAX  = (T_MAX0 > T_ERASE_CLKS) ? T_MAX0 : T_ERASE_CLKS;
  localparam int CW     = $clog2(T_MAX + 1);
  localparam int BW     = 15;
  localparam logic [BW-1:0] BUS_IDLE = {1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 8'h00};

  logic [BW-1:0] raw_bus, syn_bus;
  logic          spare_s, wp_s, ce_s, cle_s, ale_s, we_s, re_s;
  logic [7:0]    din_s;
  logic          we_d, re_d, we_rise, re_fall;

  logic          start, busy;
  job_t          job;
  logic [CW-1:0] dur;
  logic          wr_en, rd_en, alt_sel;
  logic [AW-1:0] wr_addr, rd_addr;
  logic [7:0]    wr_data, rd_data, alt_byte;

  assign raw_bus = {spare_sel, wp_n, ce_n, cle, ale, we_n, re_n, dq_in};

  nfb_sync #(.W(BW), .STAGES(SYNC_STAGES), .INIT(BUS_IDLE)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (raw_bus),
    .q   (syn_bus)
  );

  assign {spare_s, wp_s, ce_s, cle_s, ale_s, we_s, re_s, din_s} = syn_bus;

  always_ff @(posedge clk) begin
    if (rst) begin
      we_d <= 1'b1;
      re_d <= 1'b1;
    end else begin
      we_d <= we_s;
      re_d <= re_s;
    end
  end

  assign we_rise = we_s && !we_d;
  assign re_fall = !re_s && re_d;

  nfb_ctrl #(.MAIN_BYTES(MAIN_BYTES), .SPARE_BYTES(SPARE_BYTES), .AW(AW)) u_ctrl (
    .clk         (clk),
    .rst         (rst),
    .we_rise     (we_rise),
    .re_fall     (re_fall),
    .ce_n_s      (ce_s),
    .cle_s       (cle_s),
    .ale_s       (ale_s),
    .re_n_s      (re_s),
    .wp_n_s      (wp_s),
    .spare_off_s (spare_s),
    .din         (din_s),
    .busy        (busy),
    .start       (start),
    .job         (job),
    .wr_en       (wr_en),
    .wr_addr     (wr_addr),
    .wr_data     (wr_data),
    .rd_en       (rd_en),
    .rd_addr     (rd_addr),
    .alt_sel     (alt_sel),
    .alt_byte    (alt_byte),
    .oe          (dq_oe)
  );

  always_comb begin
    case (job)
      JOB_PROG:  dur = CW'(T_PROG_CLKS);
      JOB_ERASE: dur = CW'(T_ERASE_CLKS);
      default:   dur = CW'(T_READ_CLKS);
    endcase
  end

  nfb_busy_timer #(.CNT_W(CW)) u_timer (
    .clk   (clk),
    .rst   (rst),
    .start (start),
    .dur   (dur),
    .busy  (busy)
  );

  nfb_page_buf #(.DEPTH(DEPTH), .AW(AW)) u_buf (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .rd_en   (rd_en),
    .rd_addr (rd_addr),
    .rd_data (rd_data)
  );

  assign dq_out = alt_sel ? alt_byte : rd_data;
  assign rb_n   = !busy;

  // R7: once busy, the ready line stays low for at least a second clock
  p_busy_min_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |=> busy);

endmodule

// File: tb/tb_nand_bus_front.sv
module tb_nand_bus_front;

  localparam int T_RD = 12;
  localparam int T_PG = 40;
  localparam int T_ER = 120;
  localparam int NPAGE = 528;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ce_n = 1'b1, cle = 1'b0, ale = 1'b0, we_n = 1'b1, re_n = 1'b1;
  logic wp_n = 1'b1, spare_sel = 1'b0;
  logic [7:0] dq_in = 8'h00;
  logic [7:0] dq_out;
  logic dq_oe, rb_n;

  int total = 0;
  int bad = 0;
  bit done = 0;
  int ce_hi_run = 0;
  logic [7:0] model_page [NPAGE];

  always #4 clk = ~clk;

  nand_bus_front dut (
    .clk(clk), .rst(rst), .ce_n(ce_n), .cle(cle), .ale(ale), .we_n(we_n),
    .re_n(re_n), .wp_n(wp_n), .spare_sel(spare_sel), .dq_in(dq_in),
    .dq_out(dq_out), .dq_oe(dq_oe), .rb_n(rb_n)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // R4 every clock: after a long deselect the bus must be released
  always @(negedge clk) begin
    if (!rst && !done) begin
      if (ce_n) ce_hi_run++;
      else      ce_hi_run = 0;
      if (ce_hi_run >= 4) chk("R4 oe while deselected", int'(dq_oe), 0);
    end
  end

  task automatic put_byte(input logic c, input logic a, input logic [7:0] d,
                          input bit meas, input bit drop_ce, output int low);
    bit seen;
    cle = c; ale = a; dq_in = d; we_n = 1'b0;
    repeat (4) @(negedge clk);
    we_n = 1'b1;
    low = 0;
    seen = 0;
    if (!meas) begin
      repeat (4) @(negedge clk);
    end else begin
      for (int i = 0; i < 2000; i++) begin
        @(negedge clk);
        if (drop_ce && i == 3) ce_n = 1'b1;
        if (!rb_n) begin
          seen = 1;
          low++;
        end else if (seen || i >= 6) begin
          break;
        end
      end
    end
    cle = 1'b0; ale = 1'b0;
  endtask

  task automatic cmd(input logic [7:0] d);
    int lw;
    put_byte(1'b1, 1'b0, d, 1'b0, 1'b0, lw);
  endtask

  task automatic adr(input logic [7:0] d);
    int lw;
    put_byte(1'b0, 1'b1, d, 1'b0, 1'b0, lw);
  endtask

  task automatic dat(input logic [7:0] d);
    int lw;
    put_byte(1'b0, 1'b0, d, 1'b0, 1'b0, lw);
  endtask

  task automatic get_byte(output logic [7:0] d, output logic oe_on, output logic oe_off);
    re_n = 1'b0;
    repeat (4) @(negedge clk);
    d = dq_out;
    oe_on = dq_oe;
    re_n = 1'b1;
    repeat (4) @(negedge clk);
    oe_off = dq_oe;
  endtask

  task automatic start_read(input logic [7:0] col, output int low);
    cmd(8'h00);
    adr(col);
    adr(8'h03);
    put_byte(1'b0, 1'b1, 8'h00, 1'b1, 1'b0, low);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : main
    int lw;
    logic [7:0] b;
    logic on, off;

    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: idle outputs after reset
    chk("R1 rb_n", int'(rb_n), 1);
    chk("R1 dq_oe", int'(dq_oe), 0);
    ce_n = 1'b0;
    repeat (4) @(negedge clk);
    cmd(8'h70);
    get_byte(b, on, off);
    chk("R1 R10 reset status", int'(b), 8'hC0);
    chk("R4 oe on status", int'(on), 1);
    chk("R4 oe released", int'(off), 0);

    // R5: program 8 bytes at column 0x10
    cmd(8'h80); adr(8'h10); adr(8'h01); adr(8'h02);
    for (int i = 0; i < 8; i++) begin
      model_page[16 + i] = 8'(8'hA0 + i * 3);
      dat(model_page[16 + i]);
    end
    put_byte(1'b1, 1'b0, 8'h10, 1'b1, 1'b0, lw);
    chk("R5 program busy clocks", lw, T_PG);

    // R2 R3: read back from column 0x10
    start_read(8'h10, lw);
    chk("R3 read busy clocks", lw, T_RD);
    for (int i = 0; i < 8; i++) begin
      get_byte(b, on, off);
      chk("R3 read data", int'(b), int'(model_page[16 + i]));
      chk("R4 oe during read", int'(on), 1);
      chk("R4 oe after read", int'(off), 0);
    end

    // R2: column byte selects the start point
    start_read(8'h12, lw);
    get_byte(b, on, off);
    chk("R2 column start", int'(b), int'(model_page[18]));
    get_byte(b, on, off);
    chk("R2 column step", int'(b), int'(model_page[19]));

    // R8: strobes while deselected are ignored
    ce_n = 1'b1;
    repeat (4) @(negedge clk);
    cmd(8'h70);
    get_byte(b, on, off);
    chk("R8 no oe while deselected", int'(on), 0);
    ce_n = 1'b0;
    repeat (4) @(negedge clk);
    get_byte(b, on, off);
    chk("R8 counter unchanged", int'(b), int'(model_page[20]));

    // R6 R7: erase, deselecting during busy
    cmd(8'h60); adr(8'h04); adr(8'h00);
    put_byte(1'b1, 1'b0, 8'hD0, 1'b1, 1'b1, lw);
    chk("R6 R7 erase busy clocks", lw, T_ER);
    ce_n = 1'b0;
    repeat (4) @(negedge clk);

    // R10: status during busy, other commands ignored
    cmd(8'h60); adr(8'h05); adr(8'h00); cmd(8'hD0);
    cmd(8'hFF);
    cmd(8'h70);
    get_byte(b, on, off);
    chk("R10 status while busy", int'(b), 8'h80);
    chk("R4 status oe while busy", int'(on), 1);
    chk("R10 reset ignored while busy", int'(rb_n), 0);
    for (int i = 0; i < 400 && !rb_n; i++) @(negedge clk);
    get_byte(b, on, off);
    chk("R10 status after erase", int'(b), 8'hC0);

    // R9: write protect blocks program
    wp_n = 1'b0;
    repeat (4) @(negedge clk);
    cmd(8'h80); adr(8'h00); adr(8'h00); adr(8'h00);
    dat(8'h33);
    model_page[0] = 8'h33;
    put_byte(1'b1, 1'b0, 8'h10, 1'b1, 1'b0, lw);
    chk("R9 no busy when protected", lw, 0);
    cmd(8'h70);
    get_byte(b, on, off);
    chk("R9 R10 fail status", int'(b), 8'h41);
    cmd(8'h60); adr(8'h01); adr(8'h00);
    put_byte(1'b1, 1'b0, 8'hD0, 1'b1, 1'b0, lw);
    chk("R9 no erase busy when protected", lw, 0);

    // R12: reset clears fail flag and output mode
    cmd(8'hFF);
    get_byte(b, on, off);
    chk("R12 no oe after reset", int'(on), 0);
    cmd(8'h70);
    get_byte(b, on, off);
    chk("R12 fail cleared", int'(b), 8'h40);
    wp_n = 1'b1;
    repeat (4) @(negedge clk);

    // R5 R11: fill columns 248..527 plus 4 dropped bytes
    cmd(8'h80); adr(8'hF8); adr(8'h00); adr(8'h00);
    for (int c = 248; c < NPAGE + 4; c++) begin
      if (c < NPAGE) model_page[c] = 8'(c) ^ 8'h5A;
      dat(8'(c) ^ 8'h5A);
    end
    put_byte(1'b1, 1'b0, 8'h10, 1'b1, 1'b0, lw);
    chk("R5 program busy clocks long", lw, T_PG);

    // R11: spare included
    spare_sel = 1'b0;
    repeat (4) @(negedge clk);
    start_read(8'hF8, lw);
    for (int c = 248; c < NPAGE + 2; c++) begin
      get_byte(b, on, off);
      if (c < NPAGE) chk("R11 spare incl data", int'(b), int'(model_page[c]));
      else           chk("R11 past spare end", int'(b), 8'hFF);
    end

    // R11: spare excluded
    spare_sel = 1'b1;
    repeat (4) @(negedge clk);
    start_read(8'hF8, lw);
    for (int c = 248; c < 515; c++) begin
      get_byte(b, on, off);
      if (c < 512) chk("R11 main only data", int'(b), int'(model_page[c]));
      else         chk("R11 stop at main end", int'(b), 8'hFF);
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule